// File: doc/BRIEF.md
# Dynamic Bus Sizing Cycle Splitter

This block connects a 32-bit host master to a device port that reports its own width (32, 16 or 8 bits) in every cycle. The host hands over one access: a word address, active-low byte enables, a direction flag and 32-bit write data. The block then runs as many device cycles as the reported widths require. At the end of each device cycle it works out which enabled bytes are still outstanding. Bytes always stay on their own lanes: lanes 3 and 2 use bits 31..16 and lanes 1 and 0 use bits 15..0. Read bytes are collected lane by lane into a 32-bit result.

The request side is a valid/ready stream. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. While the block is busy a pending request is held back and nothing on the request pins is sampled. Completion is a plain one-cycle `done` pulse, and the collected read data is shown beside it. There is no back-pressure on completion.

Top module: `bus_size_splitter`

## Requirements
- R1: `req_ready` is 1 exactly when no device cycle is active. A request is accepted on an edge where `req_valid` and `req_ready` are both 1.
- R2: When a device cycle ends (`dev_rdy_n` sampled 0) with `dev_narrow8_n`=1 and `dev_narrow16_n`=1, the device is 32 bits wide and the request completes in that cycle.
- R3: When both `dev_narrow8_n` and `dev_narrow16_n` are sampled 0, the 8-bit rule of R4 applies.
- R4: In 8-bit width (`dev_narrow8_n`=0), the next enables are the current ones with the lowest-numbered 0 bit set to 1. Examples, written as bit3..bit0: 0000→0001 and 1100→1101.
- R5: In 16-bit width (`dev_narrow8_n`=1, `dev_narrow16_n`=0), the next enables depend on bits 1..0. If either of those bits is 0, both are set to 1 and bits 3..2 are kept. If both are already 1, the request is complete. Examples: 1001→1011, 0000→0011, 0011→done.
- R6: A request completes when its next enables would be 1111. `done` is 1 for exactly the one cycle after the final ready edge, and the block is idle in that cycle.
- R7: During a request, `dev_addr`, `dev_we` and `dev_wdata` equal the accepted request's values in every device cycle, without lane shifting.
- R8: On a read, each device cycle copies into the result only the lanes enabled in that cycle, each from its own lane of `dev_rdata`. Lanes never enabled read as 0 in `done_rdata`.
- R9: A request with enables 1111 starts no device cycle. It gives `done`=1 with `done_rdata`=0 in the next cycle.
- R10: While `dev_rdy_n` is 1, the active device cycle and its enables are held and no completion occurs. `dev_rdy_n` has no effect while idle.
- R11: After reset the block is idle: `dev_cyc`=0, `dev_be_n`=1111, `done`=0, `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW | Word address |
| req_be_n | input | 4 | Active-low byte enables |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data on natural lanes |
| dev_cyc | output | 1 | Device cycle in progress |
| dev_addr | output | AW | Word address to device |
| dev_be_n | output | 4 | Active-low byte enables of this cycle |
| dev_we | output | 1 | Direction to device |
| dev_wdata | output | 32 | Write data to device |
| dev_rdy_n | input | 1 | Active-low end of device cycle |
| dev_narrow16_n | input | 1 | Active-low 16-bit width indication |
| dev_narrow8_n | input | 1 | Active-low 8-bit width indication |
| dev_rdata | input | 32 | Read data from device |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | 32 | Collected read result |

## Verification
The assertions check several rules on every cycle:
- the idle/ready relation;
- completion after a 32-bit ready edge;
- growth by exactly one byte per 8-bit cycle;
- the low half being cleared after a 16-bit cycle;
- held enables while ready is high;
- a stable address within a request.

Other properties can only be shown by the bench's scenarios. These are the exact next-enable value for each of the ten contiguous patterns in both narrow widths, the lane-by-lane read result, the unshifted write data, and the handling of all-ones requests.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  typedef enum logic [1:0] {W32, W16, W8} width_e;
  typedef enum logic {ST_IDLE, ST_BUS} state_e;

  // 8-bit indication wins over 16-bit (R3)
  function automatic width_e decode_width(input logic n8, input logic n16);
    if (!n8)       return W8;
    else if (!n16) return W16;
    else           return W32;
  endfunction
endpackage

// File: rtl/bsz_next_be.sv
module bsz_next_be
  import bsz_pkg::*;
#(
  parameter int LANES = bsz_pkg::LANES
) (
  input  logic [LANES-1:0] cur_be_n,
  input  width_e           width,
  output logic [LANES-1:0] nxt_be_n,
  output logic             last
);
  localparam int HALF = LANES / 2;

  logic [LANES-1:0] low_bit;
  logic             found;

  // lowest enabled lane
  always_comb begin
    low_bit = '0;
    found   = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!cur_be_n[i] && !found) begin
        low_bit[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (width)
      W8:  nxt_be_n = cur_be_n | low_bit;
      W16: begin
        if (!(&cur_be_n[HALF-1:0]))
          nxt_be_n = cur_be_n | {{(LANES-HALF){1'b0}}, {HALF{1'b1}}};
        else
          nxt_be_n = '1;
      end
      default: nxt_be_n = '1;
    endcase
    last = &nxt_be_n;
  end
endmodule

// File: rtl/bsz_rd_merge.sv
module bsz_rd_merge #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               cap,
  input  logic [LANES-1:0]   be_n,
  input  logic [8*LANES-1:0] rdata,
  output logic [8*LANES-1:0] acc
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 acc[8*g +: 8] <= '0;
      else if (clr)               acc[8*g +: 8] <= '0;
      else if (cap && !be_n[g])   acc[8*g +: 8] <= rdata[8*g +: 8];
    end
  end
endmodule

// File: rtl/bsz_seq.sv
module bsz_seq
  import bsz_pkg::*;
#(
  parameter int AW    = 30,
  parameter int LANES = bsz_pkg::LANES,
  localparam int DW   = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [LANES-1:0] req_be_n,
  input  logic             req_we,
  input  logic [DW-1:0]    req_wdata,
  input  logic             rdy_n,
  input  width_e           width,
  input  logic [LANES-1:0] nxt_be_n,
  input  logic             last,
  output logic             busy,
  output logic [AW-1:0]    addr_q,
  output logic [LANES-1:0] cur_be_n,
  output logic             we_q,
  output logic [DW-1:0]    wdata_q,
  output logic             done,
  output logic             accept
);
  state_e state;

  assign busy      = (state == ST_BUS);
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_be_n <= '1;
      addr_q   <= '0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr;
          we_q    <= req_we;
          wdata_q <= req_wdata;
          if (&req_be_n) begin
            done <= 1'b1;              // empty request, no device cycle
          end else begin
            cur_be_n <= req_be_n;
            state    <= ST_BUS;
          end
        end
        ST_BUS: if (!rdy_n) begin
          if (last) begin
            done     <= 1'b1;
            cur_be_n <= '1;
            state    <= ST_IDLE;
          end else begin
            cur_be_n <= nxt_be_n;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: ready only while idle
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  // R2: 32-bit ready edge finishes the request
  p_wide_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rdy_n && width == W32) |=> (done && !busy));

  // R4 (and R3 priority): 8-bit cycle retires exactly one byte
  p_byte_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rdy_n && width == W8) |=>
      (!busy || $countones(cur_be_n) == $countones($past(cur_be_n)) + 1));

  // R5: after a 16-bit cycle the low half is retired
  p_half_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rdy_n && width == W16) |=> (!busy || &cur_be_n[LANES/2-1:0]));

  // R10: waiting cycle holds its enables
  p_hold_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rdy_n) |=> (busy && $stable(cur_be_n) && !done));

  // R7: address fixed across the extra cycles
  p_addr_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));
endmodule

// File: rtl/bus_size_splitter.sv
module bus_size_splitter
  import bsz_pkg::*;
#(
  parameter int AW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_be_n,
  input  logic          req_we,
  input  logic [31:0]   req_wdata,
  output logic          dev_cyc,
  output logic [AW-1:0] dev_addr,
  output logic [3:0]    dev_be_n,
  output logic          dev_we,
  output logic [31:0]   dev_wdata,
  input  logic          dev_rdy_n,
  input  logic          dev_narrow16_n,
  input  logic          dev_narrow8_n,
  input  logic [31:0]   dev_rdata,
  output logic          done,
  output logic [31:0]   done_rdata
);
  width_e     width;
  logic [3:0] nxt_be_n;
  logic       last;
  logic       accept;

  assign width = decode_width(dev_narrow8_n, dev_narrow16_n);

  bsz_next_be #(.LANES(LANES)) u_next (
    .cur_be_n (dev_be_n),
    .width    (width),
    .nxt_be_n (nxt_be_n),
    .last     (last)
  );

  bsz_seq #(.AW(AW), .LANES(LANES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_be_n  (req_be_n),
    .req_we    (req_we),
    .req_wdata (req_wdata),
    .rdy_n     (dev_rdy_n),
    .width     (width),
    .nxt_be_n  (nxt_be_n),
    .last      (last),
    .busy      (dev_cyc),
    .addr_q    (dev_addr),
    .cur_be_n  (dev_be_n),
    .we_q      (dev_we),
    .wdata_q   (dev_wdata),
    .done      (done),
    .accept    (accept)
  );

  bsz_rd_merge #(.LANES(LANES)) u_merge (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .cap   (dev_cyc && !dev_rdy_n && !dev_we),
    .be_n  (dev_be_n),
    .rdata (dev_rdata),
    .acc   (done_rdata)
  );
endmodule

// File: tb/sim_bus_size_splitter.sv
module sim_bus_size_splitter;
  localparam int AW = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_be_n = 4'hF;
  logic          req_we = 1'b0;
  logic [31:0]   req_wdata = '0;
  logic          dev_cyc;
  logic [AW-1:0] dev_addr;
  logic [3:0]    dev_be_n;
  logic          dev_we;
  logic [31:0]   dev_wdata;
  logic          dev_rdy_n = 1'b1;
  logic          dev_narrow16_n = 1'b1;
  logic          dev_narrow8_n = 1'b1;
  logic [31:0]   dev_rdata = '0;
  logic          done;
  logic [31:0]   done_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bus_size_splitter #(.AW(AW)) u0 (.*);

  // {pattern, next in 8-bit, next in 16-bit}; F means complete
  localparam logic [11:0] VEC [10] = '{
    12'hEFF, 12'hDFF, 12'hBFF, 12'h7FF, 12'hCDF,
    12'h9BB, 12'h37F, 12'h89B, 12'h133, 12'h013
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [3:0] be, input logic [AW-1:0] a,
                       input logic we, input logic [31:0] wd);
    req_valid = 1'b1; req_be_n = be; req_addr = a; req_we = we; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic respond(input logic n8, input logic n16, input logic [31:0] rd);
    dev_rdy_n = 1'b0; dev_narrow8_n = n8; dev_narrow16_n = n16; dev_rdata = rd;
    @(posedge clk); @(negedge clk);
    dev_rdy_n = 1'b1; dev_narrow8_n = 1'b1; dev_narrow16_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 dev_cyc", {31'b0, dev_cyc}, 0);
    chk("R11 dev_be_n", {28'b0, dev_be_n}, 32'hF);
    chk("R11 done", {31'b0, done}, 0);
    chk("R11 req_ready", {31'b0, req_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 / R5: table walk of the ten contiguous patterns
    for (int i = 0; i < 10; i++) begin
      for (int w = 0; w < 2; w++) begin
        logic [3:0] pat, exp_n;
        pat   = VEC[i][11:8];
        exp_n = (w == 0) ? VEC[i][7:4] : VEC[i][3:0];
        start(pat, 30'h123, 1'b0, 32'h0);
        chk("R1 busy req_ready", {31'b0, req_ready}, 0);
        if (w == 0) respond(1'b0, 1'b1, 32'h0);
        else        respond(1'b1, 1'b0, 32'h0);
        if (exp_n == 4'hF) begin
          chk(w == 0 ? "R4 done" : "R5 done", {31'b0, done}, 1);
          chk("R6 idle", {31'b0, dev_cyc}, 0);
        end else begin
          chk(w == 0 ? "R4 next be" : "R5 next be", {28'b0, dev_be_n}, {28'b0, exp_n});
          respond(1'b1, 1'b1, 32'h0);
          chk("R2 done", {31'b0, done}, 1);
        end
        @(negedge clk);
        chk("R6 pulse ends", {31'b0, done}, 0);
      end
    end

    // R3: both narrow pins low -> 8-bit rule
    start(4'h0, 30'h5, 1'b0, 0);
    respond(1'b0, 1'b0, 0);
    chk("R3 priority", {28'b0, dev_be_n}, 32'h1);
    respond(1'b1, 1'b1, 0);
    @(negedge clk);

    // R2: full-width read in one cycle
    start(4'h0, 30'h7, 1'b0, 0);
    respond(1'b1, 1'b1, 32'hDEADBEEF);
    chk("R2 one cycle", {31'b0, done}, 1);
    chk("R8 wide data", done_rdata, 32'hDEADBEEF);
    @(negedge clk);

    // R8: byte-wide read, lanes fill one by one
    start(4'h0, 30'h9, 1'b0, 0);
    for (int k = 0; k < 4; k++) respond(1'b0, 1'b1, {4{8'hA0 + 8'(k)}});
    chk("R8 byte merge", done_rdata, 32'hA3A2A1A0);
    @(negedge clk);

    // R8: straddling half-word read, unenabled lanes zero
    start(4'h9, 30'hB, 1'b0, 0);
    respond(1'b1, 1'b0, 32'h11223344);
    chk("R5 straddle", {28'b0, dev_be_n}, 32'hB);
    respond(1'b1, 1'b0, 32'h55667788);
    chk("R8 straddle data", done_rdata, 32'h00663300);
    @(negedge clk);

    // R10: wait states hold the cycle
    start(4'h0, 30'hD, 1'b0, 0);
    repeat (3) @(negedge clk);
    chk("R10 held be", {28'b0, dev_be_n}, 32'h0);
    chk("R10 no done", {31'b0, done}, 0);
    respond(1'b1, 1'b1, 0);
    @(negedge clk);

    // R10: ready while idle has no effect
    dev_rdy_n = 1'b0; dev_narrow8_n = 1'b0;
    @(negedge clk);
    dev_rdy_n = 1'b1; dev_narrow8_n = 1'b1;
    chk("R10 idle cyc", {31'b0, dev_cyc}, 0);
    chk("R10 idle done", {31'b0, done}, 0);

    // R7: write keeps address and unshifted data in every cycle
    start(4'h0, 30'h2AB, 1'b1, 32'hCAFEF00D);
    for (int k = 0; k < 3; k++) begin
      respond(1'b0, 1'b1, 0);
      chk("R7 addr", {2'b0, dev_addr}, 32'h2AB);
      chk("R7 wdata", dev_wdata, 32'hCAFEF00D);
      chk("R7 we", {31'b0, dev_we}, 1);
    end
    respond(1'b0, 1'b1, 0);
    chk("R6 write done", {31'b0, done}, 1);
    @(negedge clk);

    // R9: empty request
    start(4'hF, 30'h1, 1'b0, 0);
    chk("R9 done", {31'b0, done}, 1);
    chk("R9 no cycle", {31'b0, dev_cyc}, 0);
    chk("R9 data", done_rdata, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule